// File: doc/BRIEF.md
# Preset-Loadable Up/Down Counter Channel

This block is a single 24-bit up/down counter channel driven by count strobes from an external quadrature or pulse decoder. Software reaches it through two byte-wide ports. A control byte goes to one of four configuration targets, chosen by its top three bits: a command decoder, a mode register, an input/output register and an index register. A data port carries multi-byte values one byte at a time, least significant byte first, through an internal byte pointer.

The counter cannot be written directly. Software writes a preset value through the data port and then issues a command that copies the preset into the counter. To read the count, software first issues a command that snapshots the counter into an output latch, then reads that latch back through the same byte pointer. The channel supports four count modes: free-running wrap, hold at a limit, stop after one wrap, and modulo. Borrow and carry toggle flags extend the count range by one bit. A selectable event output pulses for one cycle on a chosen event. An index input can reload the counter from the preset, either on an edge or synchronously with count strobes.

Top module: `preset_counter_channel`

## Requirements
- R1: Control bits [7:5] select the target: 000 command, 001 mode, 010 input/output, 011 index; a control write with any other selector changes no register and no counter state.
- R2: Each data write stores a byte into the preset, least significant byte first (pointer 0, 1, 2). Each data access advances the byte pointer, which wraps from 2 back to 0. Command bit 0 (for example 0x01) returns the pointer to 0.
- R3: The counter changes only through counting, index loading or commands. Command 0x08 copies the preset into the counter, command 0x02 clears it, and writing the preset alone leaves the counter unchanged.
- R4: Command 0x10 copies the counter into the output latch. Data reads return the latch bytes at the pointer, least significant first. Command bits combine, so 0x11 latches and rewinds the pointer together.
- R5: Mode bits [2:1]=0 select free counting. An up step at 0xFFFFFF gives 0 and toggles the carry flag (status bit 1). A down step at 0 gives 0xFFFFFF and toggles the borrow flag (status bit 0). Command 0x04 clears both flags.
- R6: Mode bits [2:1]=1 select limit counting: the count holds at the preset when stepped up and at 0 when stepped down.
- R7: Mode bits [2:1]=2 select one-shot counting: the counter wraps like free counting and then ignores steps until command 0x02, command 0x08 or an index load reloads it.
- R8: Mode bits [2:1]=3 select modulo counting: an up step at the preset gives 0, and a down step at 0 gives the preset.
- R9: Input/output bit 0 enables counting. A strobe with counting disabled, or with up and down strobes asserted together, leaves the count unchanged. Status bit 5 shows the direction of the last counted step (1 up).
- R10: Input/output bits [4:3] choose the event driven onto event_out, which is high in the cycle after the edge that sampled the cause: 0 carry only, 1 count reaching the preset, 2 carry or borrow, 3 index.
- R11: When input/output bit 1 is 0, an index edge loads the preset into the counter; when it is 1, the index does not load. Index bit 1 selects the edge: 1 is a rising edge of index_lvl, 0 is a falling edge.
- R12: Index bit 0 requests synchronous index mode. It is accepted only while mode bits [4:3] are nonzero, and a mode write with bits [4:3]=0 clears it. In synchronous mode the index load happens on an enabled step while the index is active, not on an edge.
- R13: noise_err sets the error flag (status bit 4) and command 0x06 clears it. Command 0x18 copies the preset's low byte onto prescale. After reset, the status, latch, prescale and event output are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte; [7:5] select the target |
| dat_we | input | 1 | Data byte write strobe (preset) |
| dat_wdata | input | 8 | Data byte to write |
| dat_re | input | 1 | Data byte read strobe; advances the pointer |
| dat_rdata | output | 8 | Output latch byte at the byte pointer |
| step_up | input | 1 | Count-up strobe from the decoder |
| step_dn | input | 1 | Count-down strobe from the decoder |
| index_lvl | input | 1 | Raw index input level |
| noise_err | input | 1 | Noise error indication from the decoder |
| status | output | 8 | Borrow [0], carry [1], error [4], direction [5] |
| event_out | output | 1 | Selected one-cycle event |
| prescale | output | 8 | Filter prescaler value |

## Verification
Counting is driven from the preset values at the edges of each mode: the all-ones value, zero, and the preset itself. These show whether a step wraps, holds, stops or rolls to the preset, and whether the right toggle flag flips. The byte pointer is driven with four writes in a row, which separates a pointer that wraps from one that saturates. Commands with combined bits, and selector codes outside the four valid targets, separate a decoder that reads fields from one that reads single bits. Index stimulus is applied with both polarities, with loading enabled and disabled, and with synchronous mode requested with and without a quadrature setting. This separates edge-triggered loading from step-qualified loading.

// File: rtl/pcc_pkg.sv
`timescale 1ns/1ps
package pcc_pkg;

    typedef enum logic [2:0] {
        SEL_CMD   = 3'd0,
        SEL_MODE  = 3'd1,
        SEL_IO    = 3'd2,
        SEL_INDEX = 3'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        MODE_FREE    = 2'd0,
        MODE_LIMIT   = 2'd1,
        MODE_ONESHOT = 2'd2,
        MODE_MODULO  = 2'd3
    } count_mode_e;

    typedef enum logic [1:0] {
        EVT_CARRY = 2'd0,
        EVT_MATCH = 2'd1,
        EVT_WRAP  = 2'd2,
        EVT_INDEX = 2'd3
    } evt_src_e;

    typedef struct packed {
        logic [1:0]  quad;
        count_mode_e mode;
    } mode_cfg_t;

    typedef struct packed {
        evt_src_e src;
        logic     idx_load_n;
        logic     step_en;
    } io_cfg_t;

    typedef struct packed {
        logic pol;
        logic sync;
    } idx_cfg_t;

    typedef struct packed {
        logic clr_ptr;
        logic clr_cnt;
        logic clr_flags;
        logic clr_err;
        logic ld_cnt;
        logic ld_latch;
        logic ld_psc;
    } cmd_t;

    typedef struct packed {
        logic up_dn;
        logic err;
        logic carry_t;
        logic borrow_t;
    } flags_t;

    function automatic reg_sel_e reg_sel(input logic [7:0] b);
        return reg_sel_e'(b[7:5]);
    endfunction

    // Bit 0 rewinds the pointer; [2:1] and [4:3] are two coded fields.
    function automatic cmd_t decode_cmd(input logic [7:0] b);
        cmd_t c;
        c.clr_ptr   = b[0];
        c.clr_cnt   = (b[2:1] == 2'b01);
        c.clr_flags = (b[2:1] == 2'b10);
        c.clr_err   = (b[2:1] == 2'b11);
        c.ld_cnt    = (b[4:3] == 2'b01);
        c.ld_latch  = (b[4:3] == 2'b10);
        c.ld_psc    = (b[4:3] == 2'b11);
        return c;
    endfunction

    function automatic logic [7:0] pack_status(input flags_t f);
        return {2'b00, f.up_dn, f.err, 2'b00, f.carry_t, f.borrow_t};
    endfunction

endpackage

// File: rtl/pcc_ctl_regs.sv
`timescale 1ns/1ps
module pcc_ctl_regs import pcc_pkg::*; (
    input  logic      clk,
    input  logic      rst,
    input  logic      ctl_we,
    input  logic [7:0] ctl_wdata,
    output mode_cfg_t mode_cfg,
    output io_cfg_t   io_cfg,
    output idx_cfg_t  idx_cfg,
    output cmd_t      cmd
);
    reg_sel_e sel;
    assign sel = reg_sel(ctl_wdata);
    assign cmd = (ctl_we && sel == SEL_CMD) ? decode_cmd(ctl_wdata) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_cfg <= '0;
            io_cfg   <= '0;
            idx_cfg  <= '0;
        end else if (ctl_we) begin
            case (sel)
                SEL_MODE: begin
                    mode_cfg.quad <= ctl_wdata[4:3];
                    mode_cfg.mode <= count_mode_e'(ctl_wdata[2:1]);
                    if (ctl_wdata[4:3] == 2'b00) idx_cfg.sync <= 1'b0;
                end
                SEL_IO: begin
                    io_cfg.src        <= evt_src_e'(ctl_wdata[4:3]);
                    io_cfg.idx_load_n <= ctl_wdata[1];
                    io_cfg.step_en    <= ctl_wdata[0];
                end
                SEL_INDEX: begin
                    idx_cfg.pol  <= ctl_wdata[1];
                    idx_cfg.sync <= ctl_wdata[0] & (mode_cfg.quad != 2'b00);
                end
                default: ;
            endcase
        end
    end

    AST_SYNC_NEEDS_QUAD: assert property (@(posedge clk) disable iff (rst)
        idx_cfg.sync |-> (mode_cfg.quad != 2'b00)); // R12

    AST_UNMAPPED_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (ctl_we && ctl_wdata[7]) |=> ($stable(mode_cfg) && $stable(io_cfg) && $stable(idx_cfg))); // R1

endmodule

// File: rtl/pcc_byte_port.sv
`timescale 1ns/1ps
module pcc_byte_port #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_ptr,
    input  logic             ld_latch,
    input  logic             ld_psc,
    input  logic             dat_we,
    input  logic [7:0]       dat_wdata,
    input  logic             dat_re,
    input  logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] preset,
    output logic [7:0]       dat_rdata,
    output logic [7:0]       prescale
);
    localparam int NB = CNT_W / 8;
    localparam int PW = (NB > 1) ? $clog2(NB) : 1;
    localparam logic [PW-1:0] LAST = PW'(NB - 1);

    logic [NB-1:0][7:0] preset_q;
    logic [NB-1:0][7:0] latch_q;
    logic [PW-1:0]      ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            preset_q <= '0;
            latch_q  <= '0;
            ptr      <= '0;
            prescale <= '0;
        end else begin
            if (clr_ptr)
                ptr <= '0;
            else if (dat_we || dat_re)
                ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
            if (dat_we && !clr_ptr)
                preset_q[ptr] <= dat_wdata;
            if (ld_latch)
                latch_q <= count;
            if (ld_psc)
                prescale <= preset_q[0];
        end
    end

    assign preset    = preset_q;
    assign dat_rdata = latch_q[ptr];

    AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        ptr <= LAST); // R2

    AST_PTR_REWIND: assert property (@(posedge clk) disable iff (rst)
        clr_ptr |=> (ptr == '0)); // R2

endmodule

// File: rtl/pcc_count_core.sv
`timescale 1ns/1ps
module pcc_count_core import pcc_pkg::*; #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  count_mode_e      mode,
    input  io_cfg_t          io_cfg,
    input  idx_cfg_t         idx_cfg,
    input  logic             clr_cnt,
    input  logic             clr_flags,
    input  logic             clr_err,
    input  logic             ld_cnt,
    input  logic [CNT_W-1:0] preset,
    input  logic             step_up,
    input  logic             step_dn,
    input  logic             noise_err,
    input  logic             index_lvl,
    output logic [CNT_W-1:0] count,
    output flags_t           flags,
    output logic             event_out
);
    localparam logic [CNT_W-1:0] MAX = '1;

    logic [CNT_W-1:0] nxt;
    logic halted, idx_prev;
    logic req, idx_active, idx_edge, idx_hit, idx_load, override, take, at_edge;
    logic carry_ev, borrow_ev, match_ev, evt_d;

    always_comb begin
        req        = io_cfg.step_en & (step_up ^ step_dn);
        idx_active = idx_cfg.pol ? index_lvl : ~index_lvl;
        idx_edge   = idx_cfg.pol ? (index_lvl & ~idx_prev) : (~index_lvl & idx_prev);
        idx_hit    = idx_cfg.sync ? (idx_active & req) : idx_edge;
        idx_load   = idx_hit & ~io_cfg.idx_load_n;
        override   = clr_cnt | ld_cnt | idx_load;
        take       = req & ~halted & ~override;

        if (step_up)
            at_edge = (mode == MODE_LIMIT || mode == MODE_MODULO) ? (count == preset) : (count == MAX);
        else
            at_edge = (count == '0);

        if (!at_edge)
            nxt = step_up ? count + 1'b1 : count - 1'b1;
        else begin
            case (mode)
                MODE_LIMIT:  nxt = count;
                MODE_MODULO: nxt = step_up ? '0 : preset;
                default:     nxt = step_up ? '0 : MAX;
            endcase
        end

        carry_ev  = take & step_up & at_edge;
        borrow_ev = take & ~step_up & at_edge;
        match_ev  = take & (nxt == preset);

        case (io_cfg.src)
            EVT_CARRY: evt_d = carry_ev;
            EVT_MATCH: evt_d = match_ev;
            EVT_WRAP:  evt_d = carry_ev | borrow_ev;
            default:   evt_d = idx_hit;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count     <= '0;
            halted    <= 1'b0;
            idx_prev  <= 1'b0;
            flags     <= '0;
            event_out <= 1'b0;
        end else begin
            idx_prev  <= index_lvl;
            event_out <= evt_d;
            if (clr_cnt) begin
                count  <= '0;
                halted <= 1'b0;
            end else if (ld_cnt || idx_load) begin
                count  <= preset;
                halted <= 1'b0;
            end else if (take) begin
                count <= nxt;
                if (mode == MODE_ONESHOT && at_edge) halted <= 1'b1;
            end
            if (clr_flags) begin
                flags.carry_t  <= 1'b0;
                flags.borrow_t <= 1'b0;
            end else begin
                if (carry_ev)  flags.carry_t  <= ~flags.carry_t;
                if (borrow_ev) flags.borrow_t <= ~flags.borrow_t;
            end
            if (clr_err)        flags.err <= 1'b0;
            else if (noise_err) flags.err <= 1'b1;
            if (take) flags.up_dn <= step_up;
        end
    end

    AST_CLEAR_COUNT: assert property (@(posedge clk) disable iff (rst)
        clr_cnt |=> (count == '0)); // R3

    AST_LIMIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (req && !override && mode == MODE_LIMIT && step_up && count == preset) |=> (count == $past(count))); // R6

    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (rst)
        (halted && !override) |=> $stable(count)); // R7

    AST_MODULO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (take && mode == MODE_MODULO && step_up && count == preset) |=> (count == '0)); // R8

    AST_CARRY_FLIP: assert property (@(posedge clk) disable iff (rst)
        (carry_ev && !clr_flags) |=> (flags.carry_t != $past(flags.carry_t))); // R5

endmodule

// File: rtl/preset_counter_channel.sv
`timescale 1ns/1ps
module preset_counter_channel import pcc_pkg::*; #(
    parameter int CNT_W = 24
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ctl_we,
    input  logic [7:0] ctl_wdata,
    input  logic       dat_we,
    input  logic [7:0] dat_wdata,
    input  logic       dat_re,
    output logic [7:0] dat_rdata,
    input  logic       step_up,
    input  logic       step_dn,
    input  logic       index_lvl,
    input  logic       noise_err,
    output logic [7:0] status,
    output logic       event_out,
    output logic [7:0] prescale
);
    mode_cfg_t        mode_cfg;
    io_cfg_t          io_cfg;
    idx_cfg_t         idx_cfg;
    cmd_t             cmd;
    flags_t           flags;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] preset;

    pcc_ctl_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .ctl_we    (ctl_we),
        .ctl_wdata (ctl_wdata),
        .mode_cfg  (mode_cfg),
        .io_cfg    (io_cfg),
        .idx_cfg   (idx_cfg),
        .cmd       (cmd)
    );

    pcc_byte_port #(.CNT_W(CNT_W)) u_port (
        .clk       (clk),
        .rst       (rst),
        .clr_ptr   (cmd.clr_ptr),
        .ld_latch  (cmd.ld_latch),
        .ld_psc    (cmd.ld_psc),
        .dat_we    (dat_we),
        .dat_wdata (dat_wdata),
        .dat_re    (dat_re),
        .count     (count),
        .preset    (preset),
        .dat_rdata (dat_rdata),
        .prescale  (prescale)
    );

    pcc_count_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode_cfg.mode),
        .io_cfg    (io_cfg),
        .idx_cfg   (idx_cfg),
        .clr_cnt   (cmd.clr_cnt),
        .clr_flags (cmd.clr_flags),
        .clr_err   (cmd.clr_err),
        .ld_cnt    (cmd.ld_cnt),
        .preset    (preset),
        .step_up   (step_up),
        .step_dn   (step_dn),
        .noise_err (noise_err),
        .index_lvl (index_lvl),
        .count     (count),
        .flags     (flags),
        .event_out (event_out)
    );

    assign status = pack_status(flags);

endmodule

// File: tb/test_preset_counter_channel.sv
`timescale 1ns/1ps
module test_preset_counter_channel;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_we = 1'b0, dat_we = 1'b0, dat_re = 1'b0;
    logic [7:0] ctl_wdata = '0, dat_wdata = '0;
    logic       step_up = 1'b0, step_dn = 1'b0, index_lvl = 1'b0, noise_err = 1'b0;
    logic [7:0] dat_rdata, status, prescale;
    logic       event_out;
    logic       last_evt;
    int checks = 0, errors = 0, cyc = 0;

    preset_counter_channel i_preset_counter_channel (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .dat_we(dat_we), .dat_wdata(dat_wdata), .dat_re(dat_re), .dat_rdata(dat_rdata),
        .step_up(step_up), .step_dn(step_dn), .index_lvl(index_lvl), .noise_err(noise_err),
        .status(status), .event_out(event_out), .prescale(prescale)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc == 50000) begin
            errors++;
            $display("FAIL watchdog all-R actual %0d cycles expected completion", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic ctl(input logic [7:0] b);
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = b;
        @(negedge clk); ctl_we = 1'b0;
    endtask

    task automatic wr_byte(input logic [7:0] b);
        @(negedge clk); dat_we = 1'b1; dat_wdata = b;
        @(negedge clk); dat_we = 1'b0;
    endtask

    task automatic wr_preset(input logic [23:0] v);
        ctl(8'h01);
        for (int i = 0; i < 3; i++) wr_byte(v[8*i +: 8]);
    endtask

    task automatic load(input logic [23:0] v);
        wr_preset(v);
        ctl(8'h08);
    endtask

    task automatic read_cnt(output logic [23:0] v);
        ctl(8'h11);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); v[8*i +: 8] = dat_rdata; dat_re = 1'b1;
            @(negedge clk); dat_re = 1'b0;
        end
    endtask

    task automatic step(input logic up);
        @(negedge clk); step_up = up; step_dn = ~up;
        @(negedge clk); step_up = 1'b0; step_dn = 1'b0; last_evt = event_out;
    endtask

    task automatic set_index(input logic lvl);
        @(negedge clk); index_lvl = lvl;
        @(negedge clk); last_evt = event_out;
    endtask

    task automatic t_reset;
        logic [23:0] v;
        chk("R13 reset status", {24'd0, status}, 32'h0);
        chk("R13 reset event", {31'd0, event_out}, 32'h0);
        chk("R13 reset prescale", {24'd0, prescale}, 32'h0);
        read_cnt(v);
        chk("R4 reset count via latch", {8'd0, v}, 32'h0);
    endtask

    task automatic t_load;
        logic [23:0] v;
        load(24'h123456);
        read_cnt(v);
        chk("R3 preset to counter", {8'd0, v}, 32'h123456);
        wr_preset(24'hABCDEF);
        read_cnt(v);
        chk("R3 preset write alone", {8'd0, v}, 32'h123456);
        ctl(8'h01);
        wr_byte(8'h11); wr_byte(8'h22); wr_byte(8'h33); wr_byte(8'h44);
        ctl(8'h08);
        read_cnt(v);
        chk("R2 pointer wrap", {8'd0, v}, 32'h332244);
    endtask

    task automatic t_unmapped;
        logic [23:0] v;
        ctl(8'hE2);
        ctl(8'hC8);
        read_cnt(v);
        chk("R1 unmapped selector ignored", {8'd0, v}, 32'h332244);
    endtask

    task automatic t_steps;
        logic [23:0] v;
        step(1'b1); step(1'b1); step(1'b1);
        read_cnt(v);
        chk("R9 three up steps", {8'd0, v}, 32'h332247);
        chk("R9 direction up", {31'd0, status[5]}, 32'h1);
        step(1'b0);
        read_cnt(v);
        chk("R9 down step", {8'd0, v}, 32'h332246);
        chk("R9 direction down", {31'd0, status[5]}, 32'h0);
        @(negedge clk); step_up = 1'b1; step_dn = 1'b1;
        @(negedge clk); step_up = 1'b0; step_dn = 1'b0;
        read_cnt(v);
        chk("R9 both strobes ignored", {8'd0, v}, 32'h332246);
        ctl(8'h42);
        step(1'b1);
        read_cnt(v);
        chk("R9 disabled step ignored", {8'd0, v}, 32'h332246);
        ctl(8'h43);
    endtask

    task automatic t_free;
        logic [23:0] v;
        ctl(8'h04);
        load(24'hFFFFFF);
        step(1'b1);
        chk("R10 carry event on wrap", {31'd0, last_evt}, 32'h1);
        read_cnt(v);
        chk("R5 up wrap to zero", {8'd0, v}, 32'h0);
        chk("R5 carry toggled", {30'd0, status[1:0]}, 32'h2);
        step(1'b0);
        chk("R10 carry source ignores borrow", {31'd0, last_evt}, 32'h0);
        read_cnt(v);
        chk("R5 down wrap to max", {8'd0, v}, 32'hFFFFFF);
        chk("R5 borrow toggled", {30'd0, status[1:0]}, 32'h3);
        ctl(8'h04);
        chk("R5 flags cleared", {30'd0, status[1:0]}, 32'h0);
    endtask

    task automatic t_events;
        logic [23:0] v;
        ctl(8'h4B);
        wr_preset(24'd3); ctl(8'h08); wr_preset(24'd5);
        step(1'b1);
        chk("R10 no match below preset", {31'd0, last_evt}, 32'h0);
        step(1'b1);
        chk("R10 match at preset", {31'd0, last_evt}, 32'h1);
        ctl(8'h53);
        ctl(8'h02);
        step(1'b0);
        chk("R10 wrap source on borrow", {31'd0, last_evt}, 32'h1);
        read_cnt(v);
        chk("R5 borrow wrap value", {8'd0, v}, 32'hFFFFFF);
        ctl(8'h43);
        ctl(8'h04);
    endtask

    task automatic t_limit;
        logic [23:0] v;
        ctl(8'h22);
        load(24'd4);
        step(1'b1);
        read_cnt(v);
        chk("R6 hold at preset", {8'd0, v}, 32'd4);
        ctl(8'h02);
        step(1'b0);
        read_cnt(v);
        chk("R6 hold at zero", {8'd0, v}, 32'd0);
    endtask

    task automatic t_modulo;
        logic [23:0] v;
        ctl(8'h26);
        load(24'd4);
        step(1'b1);
        read_cnt(v);
        chk("R8 up at preset to zero", {8'd0, v}, 32'd0);
        step(1'b0);
        read_cnt(v);
        chk("R8 down at zero to preset", {8'd0, v}, 32'd4);
    endtask

    task automatic t_oneshot;
        logic [23:0] v;
        ctl(8'h24);
        ctl(8'h02);
        step(1'b0);
        read_cnt(v);
        chk("R7 wraps once", {8'd0, v}, 32'hFFFFFF);
        step(1'b0);
        read_cnt(v);
        chk("R7 stopped after wrap", {8'd0, v}, 32'hFFFFFF);
        ctl(8'h02);
        step(1'b1);
        read_cnt(v);
        chk("R7 counts after reload", {8'd0, v}, 32'd1);
    endtask

    task automatic t_index;
        logic [23:0] v;
        ctl(8'h20);
        wr_preset(24'h000777);
        ctl(8'h41);
        ctl(8'h02);
        set_index(1'b1);
        read_cnt(v);
        chk("R11 rising edge loads", {8'd0, v}, 32'h777);
        ctl(8'h60);
        ctl(8'h02);
        set_index(1'b0);
        read_cnt(v);
        chk("R11 falling edge loads", {8'd0, v}, 32'h777);
        ctl(8'h43);
        ctl(8'h62);
        ctl(8'h02);
        set_index(1'b1);
        read_cnt(v);
        chk("R11 load disabled", {8'd0, v}, 32'h0);
        set_index(1'b0);
        ctl(8'h5B);
        set_index(1'b1);
        chk("R10 index event", {31'd0, last_evt}, 32'h1);
        set_index(1'b0);
        ctl(8'h43);
    endtask

    task automatic t_sync;
        logic [23:0] v;
        ctl(8'h41);
        ctl(8'h63);
        ctl(8'h02);
        set_index(1'b1);
        read_cnt(v);
        chk("R12 sync refused without quadrature", {8'd0, v}, 32'h777);
        set_index(1'b0);
        ctl(8'h28);
        ctl(8'h63);
        ctl(8'h02);
        set_index(1'b1);
        read_cnt(v);
        chk("R12 sync ignores edge", {8'd0, v}, 32'h0);
        step(1'b1);
        read_cnt(v);
        chk("R12 sync loads on step", {8'd0, v}, 32'h777);
        set_index(1'b0);
        ctl(8'h20);
        ctl(8'h02);
        set_index(1'b1);
        read_cnt(v);
        chk("R12 quadrature off clears sync", {8'd0, v}, 32'h777);
        set_index(1'b0);
        ctl(8'h43);
    endtask

    task automatic t_err_psc;
        chk("R13 error clear", {31'd0, status[4]}, 32'h0);
        @(negedge clk); noise_err = 1'b1;
        @(negedge clk); noise_err = 1'b0;
        chk("R13 error set", {31'd0, status[4]}, 32'h1);
        ctl(8'h06);
        chk("R13 error cleared", {31'd0, status[4]}, 32'h0);
        wr_preset(24'h0000A5);
        ctl(8'h18);
        chk("R13 prescale load", {24'd0, prescale}, 32'hA5);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        ctl(8'h43);
        ctl(8'h62);
        t_load();
        t_unmapped();
        t_steps();
        t_free();
        t_events();
        t_limit();
        t_modulo();
        t_oneshot();
        t_index();
        t_sync();
        t_err_psc();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule